// File: doc/BRIEF.md
# Fixed-Point Discrete PID Position Controller

This block closes a position loop in fixed point. Each clock cycle it takes a signed target and a signed measured position, both Q8.8, and three unsigned Q0.8 gains. It forms the position error and scales three terms from it: a proportional term, a derivative term built from the change in error since the last update, and an integral term. It then registers the saturated sum as the drive command. All of this arithmetic fits inside one clock period. There is no pipeline, so a new command is available one edge after the inputs that produced it.

The integrator does not add up the raw error. Each cycle it adds the error after it has been weighted by the integral gain and rescaled. The running value is clamped to the signed 16-bit range before it is stored and before it is used. The final sum is clamped again on its own. State changes only on edges where the update enable is high. Otherwise the integrator, the stored error and the output all keep their values. The stage is fed by a sampling strobe and has no flow control, so the enable and data pins stay plain.

Top module: `pid_position_ctrl`

## Requirements
- R1: The error is target minus measured position, formed at 17 bits with sign extension. A difference of +65535 or -65535 is represented without wraparound.
- R2: The proportional term equals floor(error × gain_p / 256). gain_p is an unsigned 8-bit value from 0 to 255, so codes with the top bit set still count as positive.
- R3: The derivative term equals floor((error − stored error) × gain_d / 256). The stored error is the full 17-bit error captured at the previous enabled edge, and it is 0 after reset.
- R4: On an enabled edge the new integral equals sat(integral + floor(error × gain_i / 256)). This new value, not the old one, enters the output sum of the same cycle.
- R5: The integral state saturates at +32767 and at -32768. After saturating it moves back from the limit as soon as the weighted error changes sign.
- R6: On an enabled edge the output register loads sat(P + I + D). The value appears on drive_out one clock edge after the inputs are presented.
- R7: While upd_en is low, the output, the integral and the stored error all keep their values, and target, position and gain changes have no effect on them.
- R8: A synchronous active-high reset clears the output, the integral and the stored error to 0. Reset wins over upd_en when both are high.
- R9: Intermediate sums and products are at least 27 bits wide and signed, so results beyond the 16-bit range clamp to the correct limit and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Perform one controller update at this edge |
| target_pos | input | 16 | Desired position, signed Q8.8 |
| meas_pos | input | 16 | Measured position, signed Q8.8 |
| gain_p | input | 8 | Proportional gain, unsigned Q0.8 |
| gain_i | input | 8 | Integral gain, unsigned Q0.8 |
| gain_d | input | 8 | Derivative gain, unsigned Q0.8 |
| drive_out | output | 16 | Saturated control command, signed Q8.8, registered |

## Verification
Every result is due exactly one rising edge after the inputs that cause it. The output, the integral and the stored error all settle at that same edge. The bench therefore changes inputs on the falling edge. Its integer reference model steps at the rising edge, and drive_out is compared 1 ns later on every clock, including reset and idle cycles. The integral and the stored error are not visible directly. They are brought out by zeroing the other gains, so the output then equals the hidden state one edge later.

// File: rtl/pid_ctrl_pkg.sv
package pid_ctrl_pkg;
  localparam int unsigned PID_DATA_W  = 16;
  localparam int unsigned PID_GAIN_W  = 8;
  localparam int unsigned PID_FRAC_SH = 8;

  // Width that holds any intermediate product or sum without wraparound
  function automatic int unsigned pid_acc_width(input int unsigned dw, input int unsigned gw);
    return dw + gw + 3;
  endfunction
endpackage

// File: rtl/pid_sat.sv
module pid_sat #(
  parameter int unsigned IN_W  = 27,
  parameter int unsigned OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  v,
  output logic signed [OUT_W-1:0] y
);
  localparam logic signed [IN_W-1:0] HI_LIM = IN_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [IN_W-1:0] LO_LIM = ~HI_LIM;

  always_comb begin
    if (v > HI_LIM)      y = HI_LIM[OUT_W-1:0];
    else if (v < LO_LIM) y = LO_LIM[OUT_W-1:0];
    else                 y = v[OUT_W-1:0];
  end

  always_comb begin
    if (!$isunknown(v)) begin
      AST_SAT_SIGN: assert (y[OUT_W-1] == v[IN_W-1]); // R9
    end
  end
endmodule

// File: rtl/pid_err_track.sv
module pid_err_track #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned ERR_W  = DATA_W + 1,
  localparam int unsigned DIFF_W = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd_en,
  input  logic signed [DATA_W-1:0] target,
  input  logic signed [DATA_W-1:0] meas,
  output logic signed [ERR_W-1:0]  err,
  output logic signed [DIFF_W-1:0] err_delta
);
  logic signed [ERR_W-1:0] prev_err_q;

  assign err       = ERR_W'(target) - ERR_W'(meas);
  assign err_delta = DIFF_W'(err) - DIFF_W'(prev_err_q);

  always_ff @(posedge clk) begin
    if (rst)         prev_err_q <= '0;
    else if (upd_en) prev_err_q <= err;
  end

  AST_PREV_TRACK: assert property (@(posedge clk) disable iff (rst) upd_en |=> prev_err_q == $past(err)); // R3
  AST_PREV_HOLD: assert property (@(posedge clk) disable iff (rst) !upd_en |=> $stable(prev_err_q)); // R7
endmodule

// File: rtl/pid_gain_term.sv
module pid_gain_term #(
  parameter int unsigned IN_W   = 17,
  parameter int unsigned GAIN_W = 8,
  parameter int unsigned SHIFT  = 8,
  parameter int unsigned OUT_W  = 27
) (
  input  logic signed [IN_W-1:0]  x,
  input  logic        [GAIN_W-1:0] g,
  output logic signed [OUT_W-1:0] y
);
  logic signed [OUT_W-1:0] x_ext;
  logic signed [OUT_W-1:0] g_ext;
  logic signed [OUT_W-1:0] prod;

  assign x_ext = OUT_W'(x);
  assign g_ext = {{(OUT_W-GAIN_W){1'b0}}, g};
  assign prod  = x_ext * g_ext;
  assign y     = prod >>> SHIFT;
endmodule

// File: rtl/pid_integrator.sv
module pid_integrator #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 27
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd_en,
  input  logic signed [ACC_W-1:0]  i_step,
  output logic signed [DATA_W-1:0] integ_next,
  output logic signed [DATA_W-1:0] integ_q
);
  logic signed [ACC_W-1:0] raw_sum;

  assign raw_sum = ACC_W'(integ_q) + i_step;

  pid_sat #(.IN_W(ACC_W), .OUT_W(DATA_W)) u_int_sat (
    .v (raw_sum),
    .y (integ_next)
  );

  always_ff @(posedge clk) begin
    if (rst)         integ_q <= '0;
    else if (upd_en) integ_q <= integ_next;
  end

  AST_INT_RISE: assert property (@(posedge clk) disable iff (rst) (upd_en && i_step >= 0) |=> integ_q >= $past(integ_q)); // R4
  AST_INT_FALL: assert property (@(posedge clk) disable iff (rst) (upd_en && i_step < 0) |=> integ_q <= $past(integ_q)); // R5
  AST_INT_HOLD: assert property (@(posedge clk) disable iff (rst) !upd_en |=> $stable(integ_q)); // R7
endmodule

// File: rtl/pid_position_ctrl.sv
module pid_position_ctrl
  import pid_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W  = PID_DATA_W,
  parameter int unsigned GAIN_W  = PID_GAIN_W,
  parameter int unsigned FRAC_SH = PID_FRAC_SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] target_pos,
  input  logic [DATA_W-1:0] meas_pos,
  input  logic [GAIN_W-1:0] gain_p,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [GAIN_W-1:0] gain_d,
  output logic [DATA_W-1:0] drive_out
);
  localparam int unsigned ERR_W  = DATA_W + 1;
  localparam int unsigned DIFF_W = DATA_W + 2;
  localparam int unsigned ACC_W  = pid_acc_width(DATA_W, GAIN_W);
  localparam int unsigned N_ERR_TERMS = 2; // index 0: proportional, 1: integral step

  logic signed [ERR_W-1:0]  err;
  logic signed [DIFF_W-1:0] err_delta;
  logic [N_ERR_TERMS-1:0][GAIN_W-1:0] err_gains;
  logic signed [ACC_W-1:0]  err_terms [N_ERR_TERMS];
  logic signed [ACC_W-1:0]  d_term;
  logic signed [DATA_W-1:0] integ_next;
  logic signed [DATA_W-1:0] integ_q;
  logic signed [ACC_W-1:0]  pid_sum;
  logic signed [DATA_W-1:0] out_next;
  logic signed [DATA_W-1:0] out_q;
  logic                     rst_d;

  pid_err_track #(.DATA_W(DATA_W)) u_err (
    .clk       (clk),
    .rst       (rst),
    .upd_en    (upd_en),
    .target    ($signed(target_pos)),
    .meas      ($signed(meas_pos)),
    .err       (err),
    .err_delta (err_delta)
  );

  assign err_gains = {gain_i, gain_p};

  for (genvar gi = 0; gi < N_ERR_TERMS; gi++) begin : g_err_term
    pid_gain_term #(.IN_W(ERR_W), .GAIN_W(GAIN_W), .SHIFT(FRAC_SH), .OUT_W(ACC_W)) u_term (
      .x (err),
      .g (err_gains[gi]),
      .y (err_terms[gi])
    );
  end

  pid_gain_term #(.IN_W(DIFF_W), .GAIN_W(GAIN_W), .SHIFT(FRAC_SH), .OUT_W(ACC_W)) u_dterm (
    .x (err_delta),
    .g (gain_d),
    .y (d_term)
  );

  pid_integrator #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_integ (
    .clk        (clk),
    .rst        (rst),
    .upd_en     (upd_en),
    .i_step     (err_terms[1]),
    .integ_next (integ_next),
    .integ_q    (integ_q)
  );

  assign pid_sum = err_terms[0] + ACC_W'(integ_next) + d_term;

  pid_sat #(.IN_W(ACC_W), .OUT_W(DATA_W)) u_out_sat (
    .v (pid_sum),
    .y (out_next)
  );

  always_ff @(posedge clk) begin
    if (rst)         out_q <= '0;
    else if (upd_en) out_q <= out_next;
  end

  always_ff @(posedge clk) rst_d <= rst;

  assign drive_out = out_q;

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst) rst_d |-> (out_q == '0 && integ_q == '0)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) !upd_en |=> $stable(out_q)); // R7
  AST_I_ONLY: assert property (@(posedge clk) disable iff (rst) (upd_en && gain_p == '0 && gain_d == '0) |=> out_q == integ_q); // R6
endmodule

// File: tb/pid_position_ctrl_tb.sv
module pid_position_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_en = 1'b0;
  logic [15:0] target_pos = '0;
  logic [15:0] meas_pos = '0;
  logic [7:0] gain_p = '0, gain_i = '0, gain_d = '0;
  logic [15:0] drive_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_int = 0, m_prev = 0, m_out = 0;

  always #10 clk = ~clk; // 50 MHz

  pid_position_ctrl dut_i (
    .clk(clk), .rst(rst), .upd_en(upd_en),
    .target_pos(target_pos), .meas_pos(meas_pos),
    .gain_p(gain_p), .gain_i(gain_i), .gain_d(gain_d),
    .drive_out(drive_out)
  );

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic model_step(input bit r, input bit e, input int sp, input int pos,
                            input int kp, input int ki, input int kd);
    int er, pt, dt, nx;
    if (r) begin
      m_int = 0; m_prev = 0; m_out = 0;
    end else if (e) begin
      er = sp - pos;
      pt = (er * kp) >>> 8;
      dt = ((er - m_prev) * kd) >>> 8;
      nx = sat16(longint'(m_int) + ((er * ki) >>> 8));
      m_out = sat16(longint'(pt) + nx + dt);
      m_int = nx;
      m_prev = er;
    end
  endtask

  task automatic cyc(input bit r, input bit e, input int sp, input int pos,
                     input int kp, input int ki, input int kd, input string tag);
    int got;
    @(negedge clk);
    rst = r; upd_en = e;
    target_pos = 16'(sp); meas_pos = 16'(pos);
    gain_p = 8'(kp); gain_i = 8'(ki); gain_d = 8'(kd);
    @(posedge clk);
    model_step(r, e, sp, pos, kp, ki, kd);
    #1;
    got = int'($signed(drive_out));
    n_checks++;
    if ($isunknown(drive_out) || got != m_out) begin
      n_fail++;
      $display("FAIL %s: drive_out actual %0d expected %0d", tag, got, m_out);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    // R8: reset state
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0, 0, "R8 reset");
    // R2: proportional only, unsigned gain with top bit set, floor on negatives
    cyc(0, 1, 300, 0, 255, 0, 0, "R2");
    cyc(0, 1, 0, 300, 255, 0, 0, "R2");
    cyc(0, 1, -7, 0, 200, 0, 0, "R2");
    cyc(0, 1, 1000, -1000, 128, 0, 0, "R2");
    // R1: full-swing errors without wrap
    cyc(0, 1, 32767, -32768, 128, 0, 0, "R1");
    cyc(0, 1, -32768, 32767, 128, 0, 0, "R1");
    cyc(0, 1, 32767, -32768, 255, 0, 0, "R1 R9");
    cyc(0, 1, -32768, 32767, 255, 0, 0, "R1 R9");
    // R3: derivative from stored error
    cyc(1, 1, 0, 0, 0, 0, 0, "R8");
    cyc(0, 1, 500, 0, 0, 0, 200, "R3");
    cyc(0, 1, 500, 0, 0, 0, 200, "R3");
    cyc(0, 1, -500, 0, 0, 0, 200, "R3");
    cyc(0, 1, 32767, -32768, 0, 0, 255, "R3 R9");
    cyc(0, 1, -32768, 32767, 0, 0, 255, "R3 R9");
    // R4/R5: integral accumulates weighted error, saturates, recovers
    cyc(1, 0, 0, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 4; i++) cyc(0, 1, 300, 0, 0, 10, 0, "R4");
    for (int i = 0; i < 6; i++) cyc(0, 1, 32767, -32768, 0, 255, 0, "R5");
    cyc(0, 1, -1000, 0, 0, 255, 0, "R5");
    for (int i = 0; i < 6; i++) cyc(0, 1, -32768, 32767, 0, 255, 0, "R5");
    cyc(0, 1, 2000, 0, 0, 255, 0, "R5");
    // R4: new integral enters same-cycle sum
    cyc(0, 1, 400, 0, 64, 128, 32, "R4 R6");
    // R7: hold with changing inputs, then reveal hidden state
    for (int i = 0; i < 4; i++) cyc(0, 0, 1234 * i, -999, 77, 200, 150, "R7");
    cyc(0, 1, 0, 0, 0, 0, 0, "R7 integral held");
    cyc(0, 0, 5000, 0, 0, 0, 255, "R7");
    cyc(0, 1, 0, 0, 0, 0, 255, "R7 stored error");
    // R8: reset beats enable
    cyc(1, 1, 20000, -20000, 255, 255, 255, "R8 priority");
    cyc(0, 1, 0, 0, 0, 0, 0, "R8 state cleared");
    // R6/R9: combined sums beyond range
    cyc(0, 1, 32767, -32768, 255, 255, 255, "R6 R9");
    cyc(0, 1, -32768, 32767, 255, 255, 255, "R6 R9");
    cyc(0, 1, 100, 50, 90, 40, 20, "R6");
    // R6: pseudo-random traffic
    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      int sp, pos, kp, ki, kd;
      bit e, r;
      seed = seed * 32'd1664525 + 32'd1013904223;
      sp = int'($signed(seed[31:16]));
      seed = seed * 32'd1664525 + 32'd1013904223;
      pos = int'($signed(seed[31:16]));
      kp = int'(seed[7:0]); ki = int'(seed[15:8]);
      seed = seed * 32'd1664525 + 32'd1013904223;
      kd = int'(seed[23:16]);
      e = (seed[3:2] != 2'b00);
      r = (seed[12:8] == 5'd0);
      cyc(r, e, sp, pos, kp, ki, kd, "R6 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule